// File: doc/BRIEF.md
# Stack Pointer Sequencer

This block owns the processor's 16-bit stack pointer and turns stack commands into byte-wide accesses on a simple memory port. It accepts five commands: push one byte, push two bytes, pop one byte, pop two bytes, and a direct pointer load. It also accepts two mode commands that select between the confined (emulation) mode and the full-width (native) mode. Multi-byte commands are split into back-to-back single-byte memory cycles, and popped bytes are reassembled into a 16-bit result.

In emulation mode the pointer can never leave the 0x01xx page. Every change to it keeps only the low byte and forces the high byte to 0x01. In native mode all 16 bits are kept and the pointer wraps modulo 2^16. Every stack address sits in bank zero of the 24-bit address space.

A command is taken when `cmd_valid` is high and `busy` is low. The first memory access happens in the cycle after the command is taken, and each access lasts one cycle. The memory returns read data combinationally in the same cycle as `mem_re`.

Top module: `stkptr_unit`

## Requirements
- R1: After reset the pointer reads 0x01FF, `emu` is 1, `busy` is 0, and no memory strobe is active.
- R2: In emulation mode every pointer update (step, wrap or load) stores 0x01 in the high byte and the new value in the low byte. 0x0100 steps down to 0x01FF, and 0x01FF steps up to 0x0100.
- R3: In native mode the full 16-bit value is stored and stepping wraps modulo 2^16 (0x0000 steps down to 0xFFFF).
- R4: A byte push (op 1, data in `cmd_wdata[7:0]`) writes at the current pointer in the cycle after acceptance. The pointer then drops by one.
- R5: A byte pop (op 3) first moves the pointer up by one, then reads at the new value. The result appears as {0x00, byte} on `pop_data`, with `pop_valid` high for one cycle after the access.
- R6: A word push (op 2) writes `cmd_wdata[15:8]` at the pointer, then `cmd_wdata[7:0]` at pointer-1, in two consecutive cycles. The pointer ends two lower.
- R7: A word pop (op 4) reads the low byte at pointer+1, then the high byte at pointer+2. The result on `pop_data` is {high, low}.
- R8: Stack addresses are zero-extended into bank 0. At most one of `mem_we` and `mem_re` is high in any cycle.
- R9: `busy` is high in exactly the memory-access cycles. A command presented while `busy` is high is ignored.
- R10: A load (op 5) takes effect at the accepting edge, applying the R2 rule in emulation mode. It makes no memory access and never raises `busy`.
- R11: Op 7 selects native mode and leaves the pointer unchanged. Op 6 selects emulation mode and rewrites the high byte of the pointer to 0x01. Op 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_wdata | input | 16 | Push data or load value |
| busy | output | 1 | Access sequence in progress |
| mem_addr | output | 24 | Stack byte address |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Read byte, valid with mem_re |
| pop_data | output | 16 | Reassembled pop result |
| pop_valid | output | 1 | Pop result strobe |
| sp | output | 16 | Current stack pointer |
| emu | output | 1 | Emulation mode flag |

## Verification
Two functions can land in the same cycle: a new command arriving, and the second access of a word sequence. The bench provokes this by holding a load command on the strobe through both access cycles of a word push. It then judges the outcome in two places. The bytes written must land at the addresses R6 predicts, and the final pointer must be the post-push value rather than the load value. Wrap cases at the edge of page 1 and at 0x0000 in native mode are also checked, in the same cycles where the access address is formed.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_PUSH8  = 3'd1,
    OP_PUSH16 = 3'd2,
    OP_POP8   = 3'd3,
    OP_POP16  = 3'd4,
    OP_LOAD   = 3'd5,
    OP_EMU    = 3'd6,
    OP_NAT    = 3'd7
  } stk_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FIRST = 2'd1,
    SQ_LAST  = 2'd2
  } seq_state_e;

  localparam int          SP_W     = 16;
  localparam int          BYTE_W   = 8;
  localparam logic [7:0]  EMU_PAGE = 8'h01;

  // Apply the mode rule to a candidate pointer value.
  function automatic logic [SP_W-1:0] confine(input logic [SP_W-1:0] v,
                                              input logic emu_m);
    return emu_m ? {EMU_PAGE, v[BYTE_W-1:0]} : v;
  endfunction

endpackage

// File: rtl/stkptr_ptr.sv
module stkptr_ptr
  import stkptr_pkg::*;
#(
  parameter logic [SP_W-1:0] RESET_SP = 16'h01FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_up,
  input  logic            step_dn,
  input  logic            ld_en,
  input  logic [SP_W-1:0] ld_val,
  input  logic            go_emu,
  input  logic            go_nat,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_up,
  output logic            emu
);

  logic [SP_W-1:0] sp_q, sp_d;
  logic            emu_q, emu_d;
  logic            sp_en, emu_en;

  always_comb begin
    sp_up  = confine(sp_q + 16'd1, emu_q);
    sp_d   = sp_q;
    emu_d  = emu_q;
    sp_en  = 1'b0;
    emu_en = 1'b0;
    if (step_up) begin
      sp_d  = sp_up;
      sp_en = 1'b1;
    end else if (step_dn) begin
      sp_d  = confine(sp_q - 16'd1, emu_q);
      sp_en = 1'b1;
    end else if (ld_en) begin
      sp_d  = confine(ld_val, emu_q);
      sp_en = 1'b1;
    end else if (go_emu) begin
      sp_d   = confine(sp_q, 1'b1);
      emu_d  = 1'b1;
      sp_en  = 1'b1;
      emu_en = 1'b1;
    end else if (go_nat) begin
      emu_d  = 1'b0;
      emu_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= RESET_SP;
      emu_q <= 1'b1;
    end else begin
      if (sp_en)  sp_q  <= sp_d;
      if (emu_en) emu_q <= emu_d;
    end
  end

  assign sp  = sp_q;
  assign emu = emu_q;

  AST_EMU_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    emu_q |-> sp_q[SP_W-1:BYTE_W] == EMU_PAGE); // R2

  AST_NAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!emu_q && step_dn && sp_q == 16'h0000) |=> sp_q == 16'hFFFF); // R3

endmodule

// File: rtl/stkptr_seq.sv
module stkptr_seq
  import stkptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [SP_W-1:0]   cmd_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              acc_push,
  output logic              acc_pop,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              ld_en,
  output logic [SP_W-1:0]   ld_val,
  output logic              go_emu,
  output logic              go_nat,
  output logic [SP_W-1:0]   pop_data,
  output logic              pop_valid
);

  seq_state_e        st_q, st_d;
  logic              is_pop_q, is_pop_d;
  logic              word_q, word_d;
  logic [SP_W-1:0]   dat_q, dat_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic [SP_W-1:0]   res_q, res_d;
  logic              pv_d;
  logic              take, hold_en, lo_en, res_en;
  stk_op_e           op;

  assign op   = stk_op_e'(cmd_op);
  assign busy = (st_q != SQ_IDLE);
  assign take = cmd_valid && !busy;

  // Pointer commands act at the accepting edge.
  assign ld_en  = take && (op == OP_LOAD);
  assign ld_val = cmd_wdata;
  assign go_emu = take && (op == OP_EMU);
  assign go_nat = take && (op == OP_NAT);

  assign acc_push = busy && !is_pop_q;
  assign acc_pop  = busy && is_pop_q;

  always_comb begin
    st_d     = st_q;
    is_pop_d = is_pop_q;
    word_d   = word_q;
    dat_d    = dat_q;
    hold_en  = 1'b0;
    lo_d     = mem_rdata;
    lo_en    = 1'b0;
    res_d    = res_q;
    res_en   = 1'b0;
    pv_d     = 1'b0;
    mem_wdata = '0;
    unique case (st_q)
      SQ_IDLE: begin
        if (take && (op == OP_PUSH8 || op == OP_PUSH16 ||
                     op == OP_POP8  || op == OP_POP16)) begin
          st_d     = SQ_FIRST;
          is_pop_d = (op == OP_POP8) || (op == OP_POP16);
          word_d   = (op == OP_PUSH16) || (op == OP_POP16);
          dat_d    = cmd_wdata;
          hold_en  = 1'b1;
        end
      end
      SQ_FIRST: begin
        mem_wdata = word_q ? dat_q[SP_W-1:BYTE_W] : dat_q[BYTE_W-1:0];
        if (word_q) begin
          st_d  = SQ_LAST;
          lo_en = is_pop_q;
        end else begin
          st_d = SQ_IDLE;
          if (is_pop_q) begin
            res_d  = {{BYTE_W{1'b0}}, mem_rdata};
            res_en = 1'b1;
            pv_d   = 1'b1;
          end
        end
      end
      SQ_LAST: begin
        mem_wdata = dat_q[BYTE_W-1:0];
        st_d      = SQ_IDLE;
        if (is_pop_q) begin
          res_d  = {mem_rdata, lo_q};
          res_en = 1'b1;
          pv_d   = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      is_pop_q  <= 1'b0;
      word_q    <= 1'b0;
      dat_q     <= '0;
      lo_q      <= '0;
      res_q     <= '0;
      pop_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      pop_valid <= pv_d;
      if (hold_en) begin
        is_pop_q <= is_pop_d;
        word_q   <= word_d;
        dat_q    <= dat_d;
      end
      if (lo_en)  lo_q  <= lo_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign pop_data = res_q;

  AST_POPV_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> $past(acc_pop)); // R5

  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_en && !go_emu && !go_nat); // R9

endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
  import stkptr_pkg::*;
#(
  parameter int               ADDR_W   = 24,
  parameter logic [SP_W-1:0]  RESET_SP = 16'h01FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [SP_W-1:0]   cmd_wdata,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_re,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [SP_W-1:0]   pop_data,
  output logic              pop_valid,
  output logic [SP_W-1:0]   sp,
  output logic              emu
);

  localparam int BANK_W = ADDR_W - SP_W;

  logic            acc_push, acc_pop, ld_en, go_emu, go_nat;
  logic [SP_W-1:0] ld_val, sp_up;

  stkptr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_wdata (cmd_wdata),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .acc_push  (acc_push),
    .acc_pop   (acc_pop),
    .mem_wdata (mem_wdata),
    .ld_en     (ld_en),
    .ld_val    (ld_val),
    .go_emu    (go_emu),
    .go_nat    (go_nat),
    .pop_data  (pop_data),
    .pop_valid (pop_valid)
  );

  stkptr_ptr #(.RESET_SP(RESET_SP)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_up (acc_pop),
    .step_dn (acc_push),
    .ld_en   (ld_en),
    .ld_val  (ld_val),
    .go_emu  (go_emu),
    .go_nat  (go_nat),
    .sp      (sp),
    .sp_up   (sp_up),
    .emu     (emu)
  );

  assign mem_we   = acc_push;
  assign mem_re   = acc_pop;
  assign mem_addr = {{BANK_W{1'b0}}, (acc_pop ? sp_up : sp)};

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R8

  AST_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> mem_addr[ADDR_W-1:SP_W] == '0); // R8

  AST_WRITE_THEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp == confine($past(mem_addr[SP_W-1:0]) - 16'd1, emu)); // R4

  AST_READ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> sp == $past(mem_addr[SP_W-1:0])); // R5

endmodule

// File: tb/stkptr_unit_tb_top.sv
`timescale 1ns/1ps
module stkptr_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [15:0] cmd_wdata;
  logic        busy;
  logic [23:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic        mem_re;
  logic [7:0]  mem_rdata;
  logic [15:0] pop_data;
  logic        pop_valid;
  logic [15:0] sp;
  logic        emu;

  logic [7:0]  mem [0:255];
  int          n_chk;
  int          n_bad;
  bit          finished;

  stkptr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .pop_data(pop_data), .pop_valid(pop_valid), .sp(sp), .emu(emu)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present a command for one edge; returns at the negedge after acceptance.
  task automatic issue(input logic [2:0] op, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic t_reset;
    chk("R1 sp", sp, 32'h01FF);
    chk("R1 emu", emu, 1);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {mem_we, mem_re}, 0);
  endtask

  task automatic t_byte_emu;
    issue(3'd1, 16'h00A5);
    chk("R4 we", mem_we, 1);
    chk("R4 addr", mem_addr, 32'h0001FF);
    chk("R4 wdata", mem_wdata, 32'hA5);
    chk("R9 busy in access", busy, 1);
    @(negedge clk);
    chk("R4 sp after", sp, 32'h01FE);
    chk("R9 busy drop", busy, 0);
    issue(3'd3, 16'h0000);
    chk("R5 re", mem_re, 1);
    chk("R5 addr", mem_addr, 32'h0001FF);
    chk("R8 exclusive", mem_we, 0);
    @(negedge clk);
    chk("R5 sp", sp, 32'h01FF);
    chk("R5 valid", pop_valid, 1);
    chk("R5 data", pop_data, 32'h00A5);
    @(negedge clk);
    chk("R5 valid one cycle", pop_valid, 0);
  endtask

  task automatic t_word_emu;
    issue(3'd2, 16'hBEEF);
    chk("R6 addr hi", mem_addr, 32'h0001FF);
    chk("R6 data hi", mem_wdata, 32'hBE);
    @(negedge clk);
    chk("R6 addr lo", mem_addr, 32'h0001FE);
    chk("R6 data lo", mem_wdata, 32'hEF);
    chk("R9 busy 2nd", busy, 1);
    @(negedge clk);
    chk("R6 sp", sp, 32'h01FD);
    issue(3'd4, 16'h0000);
    chk("R7 addr lo", mem_addr, 32'h0001FE);
    @(negedge clk);
    chk("R7 addr hi", mem_addr, 32'h0001FF);
    @(negedge clk);
    chk("R7 data", pop_data, 32'hBEEF);
    chk("R7 sp", sp, 32'h01FF);
  endtask

  task automatic t_emu_wrap;
    issue(3'd5, 16'h1234);
    chk("R10 load confined", sp, 32'h0134);
    chk("R10 no busy", busy, 0);
    chk("R10 no access", {mem_we, mem_re}, 0);
    issue(3'd5, 16'h0100);
    issue(3'd1, 16'h0077);
    chk("R2 push at page bottom", mem_addr, 32'h000100);
    @(negedge clk);
    chk("R2 wrap down", sp, 32'h01FF);
    issue(3'd3, 16'h0000);
    chk("R2 wrap up addr", mem_addr, 32'h000100);
    @(negedge clk);
    chk("R2 wrap up sp", sp, 32'h0100);
    chk("R2 wrap data", pop_data, 32'h0077);
  endtask

  task automatic t_native;
    issue(3'd7, 16'h0000);
    chk("R11 native emu", emu, 0);
    chk("R11 native sp kept", sp, 32'h0100);
    issue(3'd5, 16'h0000);
    chk("R3 load full", sp, 32'h0000);
    issue(3'd2, 16'h1357);
    chk("R3 hi addr", mem_addr, 32'h000000);
    @(negedge clk);
    chk("R3 lo addr wrap", mem_addr, 32'h00FFFF);
    @(negedge clk);
    chk("R3 sp wrap", sp, 32'hFFFE);
    issue(3'd4, 16'h0000);
    chk("R3 pop lo addr", mem_addr, 32'h00FFFF);
    @(negedge clk);
    chk("R3 pop hi addr", mem_addr, 32'h000000);
    @(negedge clk);
    chk("R3 pop data", pop_data, 32'h1357);
    chk("R3 sp back", sp, 32'h0000);
    issue(3'd5, 16'h8001);
    chk("R3 load high", sp, 32'h8001);
    issue(3'd0, 16'hFFFF);
    chk("R11 nop", sp, 32'h8001);
    issue(3'd6, 16'h0000);
    chk("R11 emu back", emu, 1);
    chk("R11 emu page forced", sp, 32'h0101);
  endtask

  task automatic t_busy_ignore;
    issue(3'd2, 16'h2468);
    cmd_valid = 1'b1; cmd_op = 3'd5; cmd_wdata = 16'h0050;
    chk("R9 first access addr", mem_addr, 32'h000101);
    @(negedge clk);
    chk("R9 second access addr", mem_addr, 32'h000100);
    chk("R9 second data", mem_wdata, 32'h68);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    chk("R9 load ignored", sp, 32'h01FF);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_wdata = 16'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_byte_emu;
    t_word_emu;
    t_emu_wrap;
    t_native;
    t_busy_ignore;
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule